// File: doc/BRIEF.md
# Extended-Precision Rounder with Selectable Precision

This block takes an unrounded extended-precision value and turns it into an 80-bit packed result: a sign bit, a 15-bit biased exponent and a 64-bit significand whose top bit is the explicit integer bit. The value arrives as a sign, a 32-bit signed exponent and a 128-bit significand. The high 64 bits hold the part that is kept. The low 64 bits hold the bits below it. A precision selector picks where rounding happens inside the 64-bit significand: after 24, 53 or 64 bits. The block applies one of four rounding modes. It handles results too large for the format and results too small for it, and it reports overflow, underflow and inexact, plus a flag that says the magnitude was rounded upward.

A single-cycle `start` pulse loads the operands. The controller has three states. ST_IDLE waits for `start` and moves to ST_FIRST. ST_FIRST evaluates the rounding datapath once. If the result overflows while overflow is unmasked, or underflows while underflow is unmasked, ST_FIRST moves to ST_SECOND and rebiases the exponent by 0x6000 in the direction that brings it back into range. Otherwise ST_FIRST finishes and returns to ST_IDLE. ST_SECOND rounds the rebiased operand and always returns to ST_IDLE. `done` pulses for one cycle when the result is written, and the outputs hold until the next operation completes.

Top module: `xr_ext_rounder`

## Requirements
- R1: `prec_sel` selects the kept significand width: 00 keeps 24 bits (result bits [39:0] forced to zero), 10 keeps 53 bits (bits [10:0] forced to zero), 11 and 01 keep all 64 bits. In nearest mode the value rounds to the nearest representable value, and an exact tie goes to the value whose kept LSB is zero.
- R2: `round_mode` encodings are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The directed modes add one kept LSB only when discarded bits are nonzero and the direction points away from zero for the sign.
- R3: In 24- and 53-bit precision, any nonzero bit of `in_sig_lo` acts as a sticky bit below the rounding position. In 64-bit precision, `in_sig_lo` is the whole discarded fraction, and its bit 63 is the half-LSB weight.
- R4: When rounding carries out of the 64-bit significand, the result significand is 0x8000000000000000 and the exponent is one higher.
- R5: Overflow is declared when the exponent is above 0x7FFE, or equals 0x7FFE and rounding carries out. With overflow masked, it raises the overflow and inexact flags. The result is the largest finite value for the precision (exponent 0x7FFE) in toward-zero mode or when the direction points toward zero for the sign; in every other case the result is infinity (exponent 0x7FFF, significand 0x8000000000000000).
- R6: An exponent of zero or below shifts the significand right by (1 − exponent), with every lost bit ORed into a sticky bit, and gives exponent field 0. The exponent field becomes 1 when rounding sets the integer bit. The value is tiny when the exponent is negative, or when it is zero and the unshifted value would not carry out.
- R7: A tiny value raises underflow when discarded bits are nonzero, or when underflow is unmasked and the value is nonzero. `inx_flag` is set on overflow or when discarded bits are nonzero. `rnd_up` is set when the returned magnitude exceeds the exact one, and on overflow to infinity.
- R8: An underflow with `unf_masked` = 0 causes a second rounding with the exponent raised by 0x6000. The final flags are the OR of both passes. The result and `rnd_up` come from the second pass.
- R9: An overflow with `ovf_masked` = 0 causes a second rounding with the exponent lowered by 0x6000. The flags combine the same way as in R8.
- R10: `done` rises two cycles after `start` is sampled for a single pass and three cycles after it for two passes, and it lasts one cycle. `start` and operand changes while busy are ignored.
- R11: After reset, `done`, `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load operands and begin rounding (accepted only when idle) |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 32 | Signed biased exponent before rounding |
| in_sig_hi | input | 64 | Upper significand word, integer bit at 63 |
| in_sig_lo | input | 64 | Lower significand word (fraction below the high word) |
| prec_sel | input | 2 | Precision select (R1) |
| round_mode | input | 2 | Rounding mode (R2) |
| ovf_masked | input | 1 | 1 = overflow masked |
| unf_masked | input | 1 | 1 = underflow masked |
| done | output | 1 | One-cycle completion pulse |
| result | output | 80 | Packed sign, exponent and significand |
| ovf_flag | output | 1 | Overflow raised |
| unf_flag | output | 1 | Underflow raised |
| inx_flag | output | 1 | Inexact raised |
| rnd_up | output | 1 | Magnitude was rounded upward |

## Verification
Two functions can coincide in a single evaluation. The carry-out of the rounding increment and the overflow decision meet when the exponent is exactly 0x7FFE, because it is the carry that pushes the value over the limit. Likewise, denormal shifting and renormalisation to exponent 1 meet when a shifted value rounds up into the integer bit. Directed cases drive an all-ones significand at exponent 0x7FFE and just below zero, and random exponents are concentrated around both edges. Every outcome is compared in full (result, flags, `rnd_up` and latency) against a bench model that rounds by integer comparison of the discarded remainder, not by adding an increment.

// File: rtl/xr_pkg.sv
package xr_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } xr_rmode_t;

    typedef enum logic [1:0] {
        PC_24  = 2'b00,
        PC_RSV = 2'b01,
        PC_53  = 2'b10,
        PC_64  = 2'b11
    } xr_prec_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } xr_flags_t;

    localparam int XR_REBIAS = 32'h6000;

endpackage

// File: rtl/xr_jam_shift.sv
module xr_jam_shift #(
    parameter int W  = 128,
    parameter int AW = 33
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    localparam int LW = $clog2(W);

    logic          too_far;
    logic [LW-1:0] sh;
    logic [W-1:0]  lost_mask;

    always_comb begin
        too_far   = (amt >= AW'(W));
        sh        = amt[LW-1:0];
        lost_mask = ~({W{1'b1}} << sh);
        if (too_far)
            dout = {{(W-1){1'b0}}, |din};
        else
            dout = (din >> sh) | {{(W-1){1'b0}}, |(din & lost_mask)};
    end
endmodule

// File: rtl/xr_round_pass.sv
module xr_round_pass
    import xr_pkg::*;
#(
    parameter int SIG_W  = 64,
    parameter int EXP_W  = 32,
    parameter int FEXP_W = 15,
    parameter int PREC_S = 24,
    parameter int PREC_D = 53
) (
    input  logic                     sign,
    input  logic signed [EXP_W-1:0]  exp_in,
    input  logic [SIG_W-1:0]         sig_hi,
    input  logic [SIG_W-1:0]         sig_lo,
    input  logic [1:0]               prec,
    input  logic [1:0]               rmode,
    input  logic                     unf_masked,
    output logic [FEXP_W+SIG_W:0]    result,
    output logic                     ovf,
    output logic                     unf,
    output logic                     inx,
    output logic                     up
);
    localparam int W    = 2 * SIG_W;
    localparam int SH_W = EXP_W + 1;
    localparam logic [SIG_W-1:0] MASK_S = {SIG_W{1'b1}} >> PREC_S;
    localparam logic [SIG_W-1:0] MASK_D = {SIG_W{1'b1}} >> PREC_D;
    localparam logic [SIG_W-1:0] SIG_ONE = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic signed [EXP_W-1:0] EXP_TOP = EXP_W'((1 << FEXP_W) - 2);
    localparam logic [FEXP_W-1:0] FEXP_TOP = FEXP_W'((1 << FEXP_W) - 2);
    localparam logic [FEXP_W-1:0] FEXP_INF = {FEXP_W{1'b1}};

    xr_rmode_t       rm;
    logic            is64, nearest, away, to_max, denorm, sticky;
    logic [SIG_W-1:0] mask_hi;
    logic [W-1:0]    mask, lsb, half, inc, v, vj, vs, rb, kept, trunc;
    logic [W:0]      sum;
    logic [SH_W-1:0] shamt;
    logic            carry, carry_u, tie, tiny;
    logic [SIG_W-1:0] sig_n;
    logic [FEXP_W-1:0] exp_n;

    xr_jam_shift #(.W(W), .AW(SH_W)) u_jam (
        .din  (v),
        .amt  (shamt),
        .dout (vj)
    );

    always_comb begin
        rm      = xr_rmode_t'(rmode);
        is64    = prec[0];
        mask_hi = (prec == PC_24) ? MASK_S : (prec == PC_53) ? MASK_D : '0;
        mask    = {mask_hi, {SIG_W{1'b1}}};
        lsb     = mask + W'(1);
        half    = lsb >> 1;
        nearest = (rm == RM_NEAR);
        away    = (rm == RM_UP && !sign) || (rm == RM_DOWN && sign);
        to_max  = !nearest && !away;
        inc     = nearest ? half : (away ? mask : '0);

        sticky  = !is64 && (|sig_lo);
        v       = {sig_hi | {{(SIG_W-1){1'b0}}, sticky}, is64 ? sig_lo : '0};
        denorm  = exp_in[EXP_W-1] || (exp_in == '0);
        shamt   = SH_W'(1) - {exp_in[EXP_W-1], exp_in};
        vs      = denorm ? vj : v;

        carry_u = (v > ~inc);
        sum     = {1'b0, vs} + {1'b0, inc};
        carry   = sum[W];
        rb      = vs & mask;
        tie     = nearest && (rb == half);
        kept    = sum[W-1:0] & ~mask & ~(tie ? lsb : '0);
        trunc   = vs & ~mask;

        sig_n   = carry ? SIG_ONE : kept[W-1:SIG_W];
        exp_n   = denorm ? {{(FEXP_W-1){1'b0}}, sig_n[SIG_W-1]}
                         : exp_in[FEXP_W-1:0] + FEXP_W'(carry);

        ovf     = !denorm && ((exp_in > EXP_TOP) || (exp_in == EXP_TOP && carry));
        tiny    = denorm && ((exp_in != '0) || !carry_u);
        unf     = tiny && ((rb != '0) || ((vs != '0) && !unf_masked));
        inx     = ovf || (rb != '0);

        if (ovf) begin
            up     = !to_max;
            result = to_max ? {sign, FEXP_TOP, ~mask_hi} : {sign, FEXP_INF, SIG_ONE};
        end else begin
            up     = (rb != '0) && (carry || (kept != trunc));
            result = {sign, exp_n, sig_n};
        end
    end
endmodule

// File: rtl/xr_ext_rounder.sv
module xr_ext_rounder
    import xr_pkg::*;
#(
    parameter int SIG_W  = 64,
    parameter int EXP_W  = 32,
    parameter int FEXP_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_sign,
    input  logic [EXP_W-1:0]        in_exp,
    input  logic [SIG_W-1:0]        in_sig_hi,
    input  logic [SIG_W-1:0]        in_sig_lo,
    input  logic [1:0]              prec_sel,
    input  logic [1:0]              round_mode,
    input  logic                    ovf_masked,
    input  logic                    unf_masked,
    output logic                    done,
    output logic [FEXP_W+SIG_W:0]   result,
    output logic                    ovf_flag,
    output logic                    unf_flag,
    output logic                    inx_flag,
    output logic                    rnd_up
);
    localparam int RES_W = FEXP_W + SIG_W + 1;
    localparam logic signed [EXP_W-1:0] REBIAS = EXP_W'(XR_REBIAS);

    typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} xr_state_t;

    xr_state_t state;

    logic                    op_sign, op_om, op_um;
    logic signed [EXP_W-1:0] op_exp;
    logic [SIG_W-1:0]        op_hi, op_lo;
    logic [1:0]              op_prec, op_rm;
    xr_flags_t               first_flags;

    logic [RES_W-1:0]        p_res;
    logic                    p_ovf, p_unf, p_inx, p_up;
    logic                    redo_ovf, redo_unf, redo;
    logic signed [EXP_W-1:0] biased_exp;

    xr_round_pass #(.SIG_W(SIG_W), .EXP_W(EXP_W), .FEXP_W(FEXP_W)) u_pass (
        .sign       (op_sign),
        .exp_in     (op_exp),
        .sig_hi     (op_hi),
        .sig_lo     (op_lo),
        .prec       (op_prec),
        .rmode      (op_rm),
        .unf_masked (op_um),
        .result     (p_res),
        .ovf        (p_ovf),
        .unf        (p_unf),
        .inx        (p_inx),
        .up         (p_up)
    );

    always_comb begin
        redo_ovf   = p_ovf && !op_om;
        redo_unf   = p_unf && !op_um;
        redo       = redo_ovf || redo_unf;
        biased_exp = redo_ovf ? (op_exp - REBIAS) : (op_exp + REBIAS);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (start) state <= ST_FIRST;
                ST_FIRST:  state <= redo ? ST_SECOND : ST_IDLE;
                ST_SECOND: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // operands and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_sign     <= 1'b0;
            op_om       <= 1'b0;
            op_um       <= 1'b0;
            op_exp      <= '0;
            op_hi       <= '0;
            op_lo       <= '0;
            op_prec     <= '0;
            op_rm       <= '0;
            first_flags <= '0;
            done        <= 1'b0;
            result      <= '0;
            ovf_flag    <= 1'b0;
            unf_flag    <= 1'b0;
            inx_flag    <= 1'b0;
            rnd_up      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_sign <= in_sign;
                        op_exp  <= in_exp;
                        op_hi   <= in_sig_hi;
                        op_lo   <= in_sig_lo;
                        op_prec <= prec_sel;
                        op_rm   <= round_mode;
                        op_om   <= ovf_masked;
                        op_um   <= unf_masked;
                    end
                end
                ST_FIRST: begin
                    if (redo) begin
                        op_exp      <= biased_exp;
                        first_flags <= '{ovf: p_ovf, unf: p_unf, inx: p_inx};
                    end else begin
                        done     <= 1'b1;
                        result   <= p_res;
                        ovf_flag <= p_ovf;
                        unf_flag <= p_unf;
                        inx_flag <= p_inx;
                        rnd_up   <= p_up;
                    end
                end
                ST_SECOND: begin
                    done     <= 1'b1;
                    result   <= p_res;
                    ovf_flag <= p_ovf | first_flags.ovf;
                    unf_flag <= p_unf | first_flags.unf;
                    inx_flag <= p_inx | first_flags.inx;
                    rnd_up   <= p_up;
                end
                default: ;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: completion only follows a busy state
    assert_done_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state) != ST_IDLE);

    // R5: overflow always carries inexact
    assert_ovf_inexact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf_flag) |-> inx_flag);

    // R5: an all-ones exponent field only appears as a true infinity
    assert_inf_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[RES_W-2:SIG_W] == {FEXP_W{1'b1}}) |->
        result[SIG_W-1:0] == {1'b1, {(SIG_W-1){1'b0}}});

    // R7: rounding upward implies an inexact result
    assert_up_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rnd_up) |-> inx_flag);

    // R8: overflow and underflow never reported together
    assert_excl_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ovf_flag && unf_flag));

endmodule

// File: tb/xr_ext_rounder_test.sv
module xr_ext_rounder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_sign = 1'b0;
    logic [31:0] in_exp = '0;
    logic [63:0] in_sig_hi = '0;
    logic [63:0] in_sig_lo = '0;
    logic [1:0]  prec_sel = '0;
    logic [1:0]  round_mode = '0;
    logic        ovf_masked = 1'b1;
    logic        unf_masked = 1'b1;
    logic        done;
    logic [79:0] result;
    logic        ovf_flag, unf_flag, inx_flag, rnd_up;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xr_ext_rounder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig_hi(in_sig_hi), .in_sig_lo(in_sig_lo),
        .prec_sel(prec_sel), .round_mode(round_mode),
        .ovf_masked(ovf_masked), .unf_masked(unf_masked),
        .done(done), .result(result), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .inx_flag(inx_flag), .rnd_up(rnd_up)
    );

    task automatic chk(input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one rounding evaluation, modelled by remainder comparison
    task automatic model_pass(input logic s, input int e, input logic [63:0] hi,
                              input logic [63:0] lo, input logic [1:0] pc,
                              input logic [1:0] rm, input logic um,
                              output logic [79:0] res, output logic o,
                              output logic u, output logic x, output logic up);
        int drop, nb, sh;
        logic [127:0] w, ws, lowm, half, keep, rem, k2, keep0, rem0;
        logic inc, inc0, carry, carry0, den, tiny, tomax, away;
        logic [63:0] sig;
        logic [14:0] ex;
        drop = pc[0] ? 0 : ((pc == 2'b10) ? 11 : 40);
        nb   = 64 + drop;
        w    = {hi, lo};
        lowm = (128'd1 << nb) - 128'd1;
        half = 128'd1 << (nb - 1);
        away = (rm == 2'b10 && !s) || (rm == 2'b01 && s);
        tomax = (rm != 2'b00) && !away;
        keep0 = w >> nb;
        rem0  = w & lowm;
        inc0  = (rm == 2'b00) ? ((rem0 > half) || (rem0 == half && keep0[0]))
                              : (away && rem0 != 0);
        carry0 = ((keep0 + 128'(inc0)) >> (64 - drop)) != 0;
        den = (e <= 0);
        if (den) begin
            sh = 1 - e;
            if (sh >= 128) ws = {127'd0, |w};
            else ws = (w >> sh) | 128'(|(w & ((128'd1 << sh) - 128'd1)));
        end else ws = w;
        keep  = ws >> nb;
        rem   = ws & lowm;
        inc   = (rm == 2'b00) ? ((rem > half) || (rem == half && keep[0]))
                              : (away && rem != 0);
        k2    = keep + 128'(inc);
        carry = k2[64 - drop];
        o    = !den && (e > 32'h7FFE || (e == 32'h7FFE && carry));
        tiny = den && (e < 0 || !carry0);
        u    = tiny && (rem != 0 || (ws != 0 && !um));
        x    = o || (rem != 0);
        if (o) begin
            up  = !tomax;
            res = tomax ? {s, 15'h7FFE, ({64{1'b1}} << drop)}
                        : {s, 15'h7FFF, 64'h8000_0000_0000_0000};
        end else begin
            up  = (rem != 0) && inc;
            sig = carry ? 64'h8000_0000_0000_0000 : (k2[63:0] << drop);
            ex  = den ? {14'd0, sig[63]} : 15'(e + int'(carry));
            res = {s, ex, sig};
        end
    endtask

    task automatic model_full(input logic s, input int e, input logic [63:0] hi,
                              input logic [63:0] lo, input logic [1:0] pc,
                              input logic [1:0] rm, input logic om, input logic um,
                              output logic [79:0] res, output logic [3:0] fl,
                              output int lat, output string tag);
        logic [79:0] r1, r2;
        logic o1, u1, x1, p1, o2, u2, x2, p2;
        model_pass(s, e, hi, lo, pc, rm, um, r1, o1, u1, x1, p1);
        lat = 2;
        tag = o1 ? "R5" : ((e <= 0) ? "R6" : "R1");
        if (o1 && !om) begin
            model_pass(s, e - 24576, hi, lo, pc, rm, um, r2, o2, u2, x2, p2);
            lat = 3; tag = "R9";
        end else if (u1 && !um) begin
            model_pass(s, e + 24576, hi, lo, pc, rm, um, r2, o2, u2, x2, p2);
            lat = 3; tag = "R8";
        end else begin
            r2 = r1; o2 = 1'b0; u2 = 1'b0; x2 = 1'b0; p2 = p1;
        end
        res = r2;
        fl  = {o1 | o2, u1 | u2, x1 | x2, p2};
    endtask

    task automatic run_op(input string tag_in, input logic s, input int e,
                          input logic [63:0] hi, input logic [63:0] lo,
                          input logic [1:0] pc, input logic [1:0] rm,
                          input logic om, input logic um, input bit hold_busy);
        logic [79:0] eres;
        logic [3:0]  efl;
        int elat, cnt;
        string mtag, tag;
        model_full(s, e, hi, lo, pc, rm, om, um, eres, efl, elat, mtag);
        tag = (tag_in == "") ? mtag : tag_in;
        @(negedge clk);
        in_sign = s; in_exp = e; in_sig_hi = hi; in_sig_lo = lo;
        prec_sel = pc; round_mode = rm; ovf_masked = om; unf_masked = um;
        start = 1'b1;
        cnt = 0;
        while (cnt < 12) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                if (hold_busy) begin
                    in_exp = 32'h0000_7FFF; in_sig_hi = ~hi;
                end else start = 1'b0;
            end
            if (cnt == 2) start = 1'b0;
            if (done) break;
        end
        chk("R10", "latency", 80'(cnt), 80'(elat));
        chk(tag, "result", result, eres);
        chk("R7", "flags ovf/unf/inx/up",
            80'({ovf_flag, unf_flag, inx_flag, rnd_up}), 80'(efl));
        if (hold_busy) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R10", "no restart while busy", 80'(done), 80'd0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "done at reset", 80'(done), 80'd0);
        chk("R11", "result at reset", result, 80'd0);
        chk("R11", "flags at reset",
            80'({ovf_flag, unf_flag, inx_flag, rnd_up}), 80'd0);
        rst_n = 1'b1;

        // R1: 24-bit tie with even kept LSB stays
        run_op("R1", 1'b0, 16383, 64'h8000_0080_0000_0000, 64'd0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
        // R1: 24-bit tie with odd kept LSB rounds up
        run_op("R1", 1'b0, 16383, 64'h8000_0180_0000_0000, 64'd0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
        // R1: encoding 01 behaves as 64 bits
        run_op("R1", 1'b1, 16000, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 2'b01, 2'b00, 1'b1, 1'b1, 1'b0);
        // R2: directed modes
        run_op("R2", 1'b0, 16383, 64'h8000_0080_0000_0000, 64'd0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0);
        run_op("R2", 1'b1, 16383, 64'h8000_0000_0000_0001, 64'd5, 2'b11, 2'b01, 1'b1, 1'b1, 1'b0);
        run_op("R2", 1'b1, 16383, 64'h8000_0000_0000_0001, 64'd5, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0);
        // R3: sticky from the low word breaks a 53-bit tie
        run_op("R3", 1'b0, 16383, 64'h8000_0000_0000_0400, 64'd1, 2'b10, 2'b00, 1'b1, 1'b1, 1'b0);
        // R4: carry-out renormalises
        run_op("R4", 1'b0, 100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 2'b11, 2'b00, 1'b1, 1'b1, 1'b0);
        // R5: masked overflow to infinity and to largest finite
        run_op("R5", 1'b0, 32766, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 2'b00, 1'b1, 1'b1, 1'b0);
        run_op("R5", 1'b0, 32766, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 2'b11, 1'b1, 1'b1, 1'b0);
        // R6: masked denormal and rounding into exponent 1
        run_op("R6", 1'b0, -3, 64'h8000_0000_0000_0007, 64'd0, 2'b11, 2'b00, 1'b1, 1'b1, 1'b0);
        run_op("R6", 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0);
        // R8: unmasked underflow rebias
        run_op("R8", 1'b1, -5, 64'h8000_0000_0000_0000, 64'd0, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        // R9: unmasked overflow rebias
        run_op("R9", 1'b0, 32768, 64'hC000_0000_0000_0001, 64'd3, 2'b10, 2'b00, 1'b0, 1'b1, 1'b0);
        // R10: start held and operands changed while busy
        run_op("R10", 1'b0, 16383, 64'h8123_4567_89AB_CDEF, 64'h4000_0000_0000_0000, 2'b11, 2'b00, 1'b1, 1'b1, 1'b1);

        for (int n = 0; n < 400; n++) begin
            logic [63:0] hi, lo;
            int e;
            hi = {$urandom, $urandom};
            if ($urandom_range(0, 9) < 8) hi[63] = 1'b1;
            case ($urandom_range(0, 4))
                0: hi[39:0] = 40'h80_0000_0000;
                1: hi[10:0] = 11'h400;
                2: hi = 64'hFFFF_FFFF_FFFF_FFFF;
                default: ;
            endcase
            case ($urandom_range(0, 3))
                0: lo = {$urandom, $urandom};
                1: lo = 64'd0;
                2: lo = 64'h8000_0000_0000_0000;
                default: lo = 64'hFFFF_FFFF_FFFF_FFFF;
            endcase
            case ($urandom_range(0, 5))
                0: e = 16383 + $urandom_range(0, 12000) - 6000;
                1: e = 32764 + $urandom_range(0, 3);
                2: e = 32768 + $urandom_range(0, 4096);
                3: e = -$urandom_range(0, 70);
                4: e = -70 - $urandom_range(0, 230);
                default: e = 1 + $urandom_range(0, 1);
            endcase
            run_op("", 1'($urandom), e, hi, lo, 2'($urandom), 2'($urandom),
                   1'($urandom), 1'($urandom), 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule